// File: doc/BRIEF.md
# Pseudo-Random Pattern Lock Checker

This block watches a received serial bit stream, one bit per line-rate enable, and decides whether it carries one of two pseudo-random test sequences. A static select input picks the sequence. The first is a 15-stage maximal-length pattern. The second is a 20-stage maximal-length pattern whose output is forced high during long zero runs. The checker never stops searching. It seeds its local pattern register from the incoming bits and declares lock once enough consecutive bits have been predicted correctly. After lock it runs the register on its own and compares every received bit against the value it expects.

A single status/error output sits high while the checker has no lock. Once locked, the output drops low and rises for exactly one bit period for each mismatched bit. A lock flag and a saturating error count are also driven. The count can be cleared synchronously. A burst of errors inside a sliding window drops the lock and restarts the search.

Top module: `prbs_lock_checker`

## Requirements
- R1: With `patSel` = 0 the expected sequence obeys bit(n) = bit(n-15) XOR bit(n-14). On a clean stream after reset, `locked` is 0 after 46 accepted bits and 1 after the 47th: 15 seeding bits followed by 32 consecutive correct predictions.
- R2: With `patSel` = 1 the raw sequence obeys raw(n) = raw(n-20) XOR raw(n-17). The line bit equals raw(n), except that it is forced to 1 when raw(n) and the 13 raw bits after it are all zero. On a clean stream `locked` becomes 1 after the 52nd accepted bit: 20 seeding bits and 32 matches.
- R3: Only cycles with `bitEn` = 1 advance the checker. While `bitEn` is 0, the value of `rxBit` has no effect on `locked`, `errFlag` or `errCount`.
- R4: `errFlag` is 1 whenever `locked` is 0, including directly after reset.
- R5: While locked, `errFlag` is 0, except that a mismatched line bit accepted as bit k drives `errFlag` to 1 for exactly one bit period. That period starts when bit k+13 is accepted and is the same in both modes.
- R6: In mode 1, the forced ones inside a raw zero run of 19 bits are not reported as errors.
- R7: Lock is lost when an error brings the number of errors among the last 64 compared bits to 6. The error that reaches 6 is still pulsed and counted. Five errors inside any 64 bits keep the lock.
- R8: After a loss of lock the search restarts with fresh seeding, so a clean stream relocks 47 (mode 0) or 52 (mode 1) bits after the bit that caused the loss.
- R9: `errCount` goes up by one for each error pulse and is 0 after reset.
- R10: `errCount` saturates at all ones (0xFFFF at the default 16-bit width) and holds there.
- R11: `cntClr` clears `errCount` on the next clock edge. If a new error is counted in that same cycle, the count becomes 1.
- R12: While the checker is not locked, it produces no error pulses and does not change `errCount`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | Line-rate enable, one cycle per received bit |
| rxBit | input | 1 | Received serial data bit, valid when bitEn is high |
| patSel | input | 1 | Pattern select: 0 = 15-stage pattern, 1 = 20-stage pattern with zero suppression |
| cntClr | input | 1 | Synchronous clear strobe for the error count |
| errFlag | output | 1 | High while unlocked; one-bit-period pulses per error while locked |
| locked | output | 1 | Lock status |
| errCount | output | CNT_W (16) | Saturating error count |

## Verification
If the local pattern register took a wrong value while locked, every following comparison would depend on it. Within 13 to 20 accepted bits, `errFlag` would show a dense pulse train, and the window rule would drop `locked` after six of those pulses. A wrong seeding or match count shows up as lock arriving early or late against the exact bit indices above. A wrong window sum or history shows as a lock that survives six close errors or falls after five spread ones. The bench compares `errFlag` and `locked` after every accepted bit against its own model of the error positions, so any such fault shows up on the first wrong bit period.

// File: rtl/prbs_lock_pkg.sv
package prbs_lock_pkg;

  // pattern geometry: bit(n) = bit(n-LEN) ^ bit(n-TAP)
  localparam int SHORT_LEN = 15;
  localparam int SHORT_TAP = 14;
  localparam int LONG_LEN  = 20;
  localparam int LONG_TAP  = 17;
  // zero run length that triggers forced ones in the long pattern
  localparam int RUN_LEN   = 14;

  typedef enum logic [1:0] {
    SYNC_FILL = 2'd0,
    SYNC_HUNT = 2'd1,
    SYNC_LOCK = 2'd2
  } syncState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic seedFromLine;  // load received bits into the pattern register
    logic judgeErrors;   // compare and report errors
  } ctrlStrobe_t;

endpackage

// File: rtl/prbs_err_tally.sv
module prbs_err_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             hit,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (clr) begin
      count <= hit ? CNT_ONE : '0;
    end else if (hit && (count != CNT_MAX)) begin
      count <= count + CNT_ONE;
    end
  end

  // R10: a full count stays full unless cleared
  p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((count == CNT_MAX) && !clr) |=> (count == CNT_MAX));

  // R11: a clear leaves at most one
  p_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (count <= CNT_ONE));

  // R9: without clear the count moves by at most one
  p_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    !clr |=> ((count == $past(count)) || (count == $past(count) + CNT_ONE)));

endmodule

// File: rtl/prbs_lock_datapath.sv
module prbs_lock_datapath
  import prbs_lock_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SHORT_LEN = prbs_lock_pkg::SHORT_LEN,
  parameter int SHORT_TAP = prbs_lock_pkg::SHORT_TAP,
  parameter int LONG_LEN  = prbs_lock_pkg::LONG_LEN,
  parameter int LONG_TAP  = prbs_lock_pkg::LONG_TAP,
  parameter int RUN_LEN   = prbs_lock_pkg::RUN_LEN
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             rxBit,
  input  logic             patSel,
  input  logic             cntClr,
  input  ctrlStrobe_t      strobe,
  output logic             huntMatch,
  output logic             lineMiss,
  output logic             errPulse,
  output logic [CNT_W-1:0] errCount
);

  localparam int REG_W = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
  localparam int DLY_W = RUN_LEN - 1;

  logic [REG_W-1:0] patReg;
  logic [DLY_W-1:0] lineDly;
  logic             predBit;
  logic             quietRun;
  logic             expLine;
  logic             errEvent;

  // next raw bit of the selected sequence
  always_comb begin
    if (patSel) predBit = patReg[LONG_LEN-1] ^ patReg[LONG_TAP-1];
    else        predBit = patReg[SHORT_LEN-1] ^ patReg[SHORT_TAP-1];
  end

  // line bit expected DLY_W bits back: forced high in long mode when it
  // starts a zero run of RUN_LEN raw bits
  always_comb begin
    quietRun  = ~(|patReg[DLY_W-1:0]) & ~predBit;
    expLine   = patReg[DLY_W-1] | (patSel & quietRun);
    lineMiss  = lineDly[DLY_W-1] ^ expLine;
    huntMatch = (predBit == rxBit);
    errEvent  = bitEn & strobe.judgeErrors & lineMiss;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      patReg   <= '0;
      lineDly  <= '0;
      errPulse <= 1'b0;
    end else if (bitEn) begin
      patReg   <= {patReg[REG_W-2:0], strobe.seedFromLine ? rxBit : predBit};
      lineDly  <= {lineDly[DLY_W-2:0], rxBit};
      errPulse <= errEvent;
    end
  end

  prbs_err_tally #(.CNT_W(CNT_W)) tally_i (
    .clk   (clk),
    .rstN  (rstN),
    .clr   (cntClr),
    .hit   (errEvent),
    .count (errCount)
  );

  // R12: no pulse follows a bit judged while unlocked
  p_quiet_unlocked_r12: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && !strobe.judgeErrors) |=> !errPulse);

  // R5: a pulse lasts a whole bit period
  p_pulse_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(errPulse));

endmodule

// File: rtl/prbs_lock_ctrl.sv
module prbs_lock_ctrl
  import prbs_lock_pkg::*;
#(
  parameter int LOCK_RUN  = 32,
  parameter int WIN_LEN   = 64,
  parameter int LOSS_CNT  = 6,
  parameter int SHORT_LEN = prbs_lock_pkg::SHORT_LEN,
  parameter int LONG_LEN  = prbs_lock_pkg::LONG_LEN
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitEn,
  input  logic        patSel,
  input  logic        huntMatch,
  input  logic        lineMiss,
  output ctrlStrobe_t strobe,
  output logic        locked
);

  localparam int MAX_LEN = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
  localparam int FILL_W  = $clog2(MAX_LEN);
  localparam int MATCH_W = $clog2(LOCK_RUN);
  localparam int SUM_W   = $clog2(WIN_LEN + 1);

  syncState_e         state;
  logic [FILL_W-1:0]  fillCnt;
  logic [FILL_W-1:0]  fillLast;
  logic [MATCH_W-1:0] matchCnt;
  logic [WIN_LEN-1:0] errHist;
  logic [SUM_W-1:0]   errSum;
  logic [SUM_W-1:0]   sumNext;

  always_comb begin
    fillLast = patSel ? FILL_W'(LONG_LEN - 1) : FILL_W'(SHORT_LEN - 1);
    sumNext  = errSum + SUM_W'(lineMiss) - SUM_W'(errHist[WIN_LEN-1]);
    locked   = (state == SYNC_LOCK);
    strobe.seedFromLine = (state != SYNC_LOCK);
    strobe.judgeErrors  = (state == SYNC_LOCK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SYNC_FILL;
      fillCnt  <= '0;
      matchCnt <= '0;
      errHist  <= '0;
      errSum   <= '0;
    end else if (bitEn) begin
      unique case (state)
        SYNC_FILL: begin
          if (fillCnt == fillLast) begin
            state    <= SYNC_HUNT;
            fillCnt  <= '0;
            matchCnt <= '0;
          end else begin
            fillCnt <= fillCnt + 1'b1;
          end
        end
        SYNC_HUNT: begin
          if (!huntMatch) begin
            matchCnt <= '0;
          end else if (matchCnt == MATCH_W'(LOCK_RUN - 1)) begin
            state   <= SYNC_LOCK;
            errHist <= '0;
            errSum  <= '0;
          end else begin
            matchCnt <= matchCnt + 1'b1;
          end
        end
        SYNC_LOCK: begin
          if (sumNext >= SUM_W'(LOSS_CNT)) begin
            state   <= SYNC_FILL;
            fillCnt <= '0;
            errHist <= '0;
            errSum  <= '0;
          end else begin
            errHist <= {errHist[WIN_LEN-2:0], lineMiss};
            errSum  <= sumNext;
          end
        end
        default: state <= SYNC_FILL;
      endcase
    end
  end

  // R1: lock is only entered from a matching search bit
  p_entry_from_hunt_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> ($past(state) == SYNC_HUNT) && $past(huntMatch));

  // R7: lock is only dropped on an erroneous bit
  p_exit_on_error_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(lineMiss));

  // R7: a locked window never holds the loss threshold
  p_window_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> (errSum < SUM_W'(LOSS_CNT)));

endmodule

// File: rtl/prbs_lock_checker.sv
module prbs_lock_checker
  import prbs_lock_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int LOCK_RUN = 32,
  parameter int WIN_LEN  = 64,
  parameter int LOSS_CNT = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             rxBit,
  input  logic             patSel,
  input  logic             cntClr,
  output logic             errFlag,
  output logic             locked,
  output logic [CNT_W-1:0] errCount
);

  ctrlStrobe_t strobe;
  logic        huntMatch;
  logic        lineMiss;
  logic        errPulse;

  prbs_lock_ctrl #(
    .LOCK_RUN (LOCK_RUN),
    .WIN_LEN  (WIN_LEN),
    .LOSS_CNT (LOSS_CNT)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .bitEn     (bitEn),
    .patSel    (patSel),
    .huntMatch (huntMatch),
    .lineMiss  (lineMiss),
    .strobe    (strobe),
    .locked    (locked)
  );

  prbs_lock_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .bitEn     (bitEn),
    .rxBit     (rxBit),
    .patSel    (patSel),
    .cntClr    (cntClr),
    .strobe    (strobe),
    .huntMatch (huntMatch),
    .lineMiss  (lineMiss),
    .errPulse  (errPulse),
    .errCount  (errCount)
  );

  assign errFlag = ~locked | errPulse;

  // R4: the flag is high whenever lock is absent
  p_flag_unlocked_r4: assert property (@(posedge clk) disable iff (!rstN)
    !locked |-> errFlag);

endmodule

// File: tb/prbs_lock_checker_tb_top.sv
`timescale 1ns/1ps
module prbs_lock_checker_tb_top;

  logic clk = 1'b0, rstN = 1'b0, bitEn = 1'b0, rxBit = 1'b0, patSel = 1'b0, cntClr = 1'b0;
  logic errFlag, locked, errFlagS, lockedS;
  logic [15:0] errCount;
  logic [2:0]  errCountS;

  always #2 clk = ~clk;

  prbs_lock_checker dut_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit), .patSel(patSel),
    .cntClr(cntClr), .errFlag(errFlag), .locked(locked), .errCount(errCount));

  prbs_lock_checker #(.CNT_W(3)) dutSmall_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit), .patSel(patSel),
    .cntClr(cntClr), .errFlag(errFlagS), .locked(lockedS), .errCount(errCountS));

  localparam int N = 1024;
  logic pRaw [N];
  logic qRaw [N];
  logic qOut [N];
  int   pos;
  int   nChecks = 0;
  int   nFails = 0;
  bit   finished = 1'b0;

  typedef struct packed {
    logic       sel;
    logic [7:0] gap;
    logic [7:0] nErr;
    logic [7:0] expCnt;
    logic       expLoss;
  } row_t;

  // scenario table: select, error spacing, error count, expected count, loss
  localparam row_t ROWS [8] = '{
    '{1'b0, 8'd5,  8'd1, 8'd1, 1'b0},
    '{1'b0, 8'd3,  8'd5, 8'd5, 1'b0},
    '{1'b0, 8'd2,  8'd6, 8'd6, 1'b1},
    '{1'b1, 8'd7,  8'd5, 8'd5, 1'b0},
    '{1'b1, 8'd4,  8'd6, 8'd6, 1'b1},
    '{1'b0, 8'd12, 8'd6, 8'd6, 1'b1},
    '{1'b0, 8'd13, 8'd6, 8'd6, 1'b0},
    '{1'b0, 8'd2,  8'd9, 8'd6, 1'b1}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic streamBit(input int idx);
    return patSel ? qOut[idx] : pRaw[idx];
  endfunction

  task automatic feed(input logic flip, input logic clr);
    @(negedge clk);
    rxBit  = streamBit(pos) ^ flip;
    bitEn  = 1'b1;
    cntClr = clr;
    @(negedge clk);
    bitEn  = 1'b0;
    cntClr = 1'b0;
    rxBit  = ~rxBit;
    pos++;
  endtask

  task automatic startSel(input logic sel);
    @(negedge clk);
    rstN   = 1'b0;
    patSel = sel;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    pos  = 0;
  endtask

  task automatic clearPulse();
    @(negedge clk);
    cntClr = 1'b1;
    @(negedge clk);
    cntClr = 1'b0;
  endtask

  task automatic runRow(input row_t r);
    logic injArr [200];
    int   evPos [16];
    int   nev, mCnt, lossAt, lockLen, e, w;
    bit   mLocked, sawLoss, hit, inj;
    startSel(r.sel);
    repeat (100) feed(1'b0, 1'b0);
    check(locked == 1'b1, r.sel ? "R2 lock before row" : "R1 lock before row", locked, 1);
    clearPulse();
    check(errCount == 0, "R11 clear before row", errCount, 0);
    nev = 0; mCnt = 0; lossAt = -1; mLocked = 1'b1; sawLoss = 1'b0;
    lockLen = r.sel ? 52 : 47;
    for (int j = 0; j < 160; j++) begin
      inj = (j < int'(r.gap) * int'(r.nErr)) && ((j % int'(r.gap)) == 0);
      injArr[j] = inj;
      feed(inj, 1'b0);
      hit = 1'b0;
      e = j - 13;
      if (mLocked) begin
        if (e >= 0 && injArr[e]) begin
          hit = 1'b1;
          mCnt++;
          evPos[nev] = e;
          nev++;
          w = 0;
          for (int k = 0; k < nev; k++) if (evPos[k] >= e - 63) w++;
          if (w >= 6) begin
            mLocked = 1'b0;
            lossAt  = j;
            sawLoss = 1'b1;
          end
        end
      end else if (j - lossAt == lockLen) begin
        mLocked = 1'b1;
      end
      check(errFlag == (hit || !mLocked), sawLoss ? "R8/R12 errFlag" : "R5 errFlag",
            errFlag, (hit || !mLocked));
      check(locked == mLocked, sawLoss ? "R8 locked" : "R7 locked", locked, mLocked);
    end
    check(errCount == 16'(r.expCnt), "R9 row count", errCount, r.expCnt);
    check(sawLoss == r.expLoss, "R7 loss occurrence", sawLoss, r.expLoss);
  endtask

  initial begin
    int bad;
    bit allz;
    // 15-stage stream
    for (int n = 0; n < 15; n++) pRaw[n] = 1'((15'h4A3D >> n) & 1);
    for (int n = 15; n < N; n++) pRaw[n] = pRaw[n-15] ^ pRaw[n-14];
    // 20-stage stream with a 19-zero raw run starting at index 401
    qRaw[400] = 1'b1;
    for (int n = 401; n < 420; n++) qRaw[n] = 1'b0;
    for (int n = 419; n >= 20; n--) qRaw[n-20] = qRaw[n] ^ qRaw[n-17];
    for (int n = 420; n < N; n++) qRaw[n] = qRaw[n-20] ^ qRaw[n-17];
    for (int n = 0; n < N; n++) begin
      allz = (n + 13 < N);
      for (int k = 0; k < 14; k++) if (n + k < N && qRaw[n+k]) allz = 1'b0;
      qOut[n] = qRaw[n] | allz;
    end

    // reset state and exact lock timing, mode 0
    startSel(1'b0);
    @(negedge clk);
    check(errFlag == 1'b1, "R4 reset errFlag", errFlag, 1);
    check(locked == 1'b0, "R4 reset locked", locked, 0);
    check(errCount == 0, "R9 reset count", errCount, 0);
    repeat (46) feed(1'b0, 1'b0);
    check(locked == 1'b0, "R1 not yet locked at 46", locked, 0);
    check(errFlag == 1'b1, "R4 flag high unlocked", errFlag, 1);
    feed(1'b0, 1'b0);
    check(locked == 1'b1, "R1 locked at 47", locked, 1);
    check(errFlag == 1'b0, "R5 flag low when locked", errFlag, 0);

    // table of error scenarios
    for (int i = 0; i < 8; i++) runRow(ROWS[i]);

    // search-time error delays lock and is not counted
    startSel(1'b0);
    repeat (20) feed(1'b0, 1'b0);
    feed(1'b1, 1'b0);
    repeat (32) feed(1'b0, 1'b0);
    check(locked == 1'b0, "R12 hunt error delays lock", locked, 0);
    check(errCount == 0, "R12 hunt error not counted", errCount, 0);
    repeat (40) feed(1'b0, 1'b0);
    check(locked == 1'b1, "R1 relock after hunt error", locked, 1);
    check(errCount == 0, "R12 count after hunt", errCount, 0);

    // mode 1 lock, idle immunity, forced ones
    startSel(1'b1);
    repeat (51) feed(1'b0, 1'b0);
    check(locked == 1'b0, "R2 not yet locked at 51", locked, 0);
    feed(1'b0, 1'b0);
    check(locked == 1'b1, "R2 locked at 52", locked, 1);
    bad = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      rxBit = ~rxBit ^ c[1];
      if (errFlag || !locked) bad++;
    end
    check(bad == 0, "R3 idle cycles ignored", bad, 0);
    bad = 0;
    while (pos < 700) begin
      feed(1'b0, 1'b0);
      if (errFlag || !locked) bad++;
    end
    check(bad == 0, "R3/R6 no errors across forced run", bad, 0);
    check(errCount == 0, "R6 count across forced run", errCount, 0);

    // saturation and clear with coincident error
    startSel(1'b0);
    repeat (100) feed(1'b0, 1'b0);
    clearPulse();
    for (int j = 0; j < 190; j++) begin
      feed((j <= 12 && j % 3 == 0) || (j >= 80 && j <= 92 && j % 3 == 2) || j == 170,
           j == 183);
      if (j == 129) begin
        check(errCount == 10, "R9 count of ten", errCount, 10);
        check(errCountS == 3'd7, "R10 small counter saturated", errCountS, 7);
        check(locked == 1'b1, "R7 spread errors keep lock", locked, 1);
      end
    end
    check(errCount == 1, "R11 clear with error gives one", errCount, 1);
    check(errCountS == 3'd1, "R11 small clear with error", errCountS, 1);
    clearPulse();
    check(errCount == 0, "R11 plain clear", errCount, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule